// File: doc/BRIEF.md
# FIFO Watermark DMA Request Generator

This block drives the receive and transmit DMA request lines of one serial-port channel whose data FIFO is shared by both directions. It compares the FIFO byte count against two programmable levels. The receive request is raised when the count has climbed to the receive level. The transmit request is raised when the count has fallen below the transmit level. Each line also needs the channel enabled and its own per-direction enable bit set.

Each request works as a one-shot burst handshake. The first data-port access made while a line is high starts a burst, and that line drops. The direction then counts accesses, one serial word per access, until as many accesses as the level value have completed, the first one included. Only then can the line rise again, and only if the level condition still holds. The level value is captured when the burst starts, so a change made during a burst applies to the next burst. Turning the channel off ends both bursts at once.

Top module: `dma_wm_req`

## Requirements
- R1: `rx_req` is high exactly when `chan_en` is 1, `rx_dma_en` is 1, no receive burst is in progress, and `fifo_bytes >= rx_full_lvl`. Straight after reset, no burst is in progress.
- R2: `tx_req` is high exactly when `chan_en` is 1, `tx_dma_en` is 1, no transmit burst is in progress, and `fifo_bytes < tx_empty_lvl`.
- R3: While a direction's enable bit is 0, its request line stays low. A strobe seen while that line is low and that direction is idle starts no burst, so the line rises in the same cycle the enable bit returns to 1.
- R4: A strobe (`rx_rd_stb` or `tx_wr_stb`) sampled at a rising clock edge while the matching request is high starts a burst. For a level value above 1, the request is low from that edge on.
- R5: A burst started with level value N lasts N accesses, the starting access included. The request stays low until the edge that samples the N-th strobe. Cycles without a strobe do not advance the burst.
- R6: The level value is captured when the burst starts. Changing `rx_full_lvl` or `tx_empty_lvl` during a burst does not change the length of that burst.
- R7: While `chan_en` is 0, both requests are low and both bursts are cleared. When the channel is enabled again, each line follows R1/R2 at once.
- R8: A level value of 0 acts as a burst length of 1. A receive level of 0 is always met. A transmit level of 0 is never met, so `tx_req` stays low.
- R9: The two directions are independent. A strobe for one direction never changes the other direction's burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable |
| rx_dma_en | input | 1 | Receive request enable bit (0 masks the line) |
| tx_dma_en | input | 1 | Transmit request enable bit (0 masks the line) |
| rx_full_lvl | input | LVL_W | Receive level; also the receive burst length |
| tx_empty_lvl | input | LVL_W | Transmit level; also the transmit burst length |
| fifo_bytes | input | LVL_W | Current FIFO byte count |
| rx_rd_stb | input | 1 | One completed read of the receive data port |
| tx_wr_stb | input | 1 | One completed load into the transmit data port |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |

## Verification
All state sits in the two burst counters, and each counter appears at its request line. A counter left nonzero shows as a request held low while its level condition holds, and this is visible in the first cycle where R1 or R2 predicts a high line. A counter that clears too early, or reloads from the wrong level value, shows as a request that rises one or more accesses early or late. The bench sees that on the access where its own count of the burst runs out. A counter that one direction's strobe corrupts in the other direction shows up at the other line's next re-arm point.

// File: rtl/dma_wm_pkg.sv
package dma_wm_pkg;

  typedef enum logic { DIR_TX = 1'b0, DIR_RX = 1'b1 } wm_dir_e;

  // Accesses still owed after the access that opens a burst.
  // A level value of 0 is treated as a burst of one access.
  function automatic int unsigned burst_rest(input int unsigned lvl);
    return (lvl == 0) ? 0 : lvl - 1;
  endfunction

  // Level condition: receive needs count >= level, transmit needs count < level.
  function automatic logic level_met(input wm_dir_e dir,
                                     input int unsigned cnt,
                                     input int unsigned lvl);
    return (dir == DIR_RX) ? (cnt >= lvl) : (cnt < lvl);
  endfunction

endpackage

// File: rtl/dma_wm_lane.sv
module dma_wm_lane
  import dma_wm_pkg::*;
#(
  parameter int      LVL_W = 7,
  parameter wm_dir_e DIR   = DIR_RX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dma_en,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] fill,
  input  logic             stb,
  output logic             req
);

  logic [LVL_W-1:0] owed_q;
  logic             idle;
  logic             hit;
  logic             burst_start;
  logic             step;

  assign idle        = (owed_q == '0);
  assign hit         = level_met(DIR, 32'(fill), 32'(lvl));
  assign req         = en & dma_en & idle & hit;
  assign burst_start = req & stb;
  assign step        = en & ~idle & stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else if (!en) begin
      owed_q <= '0;
    end else if (burst_start) begin
      owed_q <= LVL_W'(burst_rest(32'(lvl)));
    end else if (step) begin
      owed_q <= owed_q - 1'b1;
    end
  end

  // R4
  burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && stb && lvl > 1) |=> !req);

  // R7
  reenable_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && en && dma_en && hit) |-> req);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stb) |=> $stable(owed_q));

  // R5
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !idle && stb) |=> (owed_q == $past(owed_q) - 1'b1));

  // R3
  mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && idle && en) |=> (owed_q == '0));

endmodule

// File: rtl/dma_wm_req.sv
module dma_wm_req
  import dma_wm_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  input  logic [LVL_W-1:0] rx_full_lvl,
  input  logic [LVL_W-1:0] tx_empty_lvl,
  input  logic [LVL_W-1:0] fifo_bytes,
  input  logic             rx_rd_stb,
  input  logic             tx_wr_stb,
  output logic             rx_req,
  output logic             tx_req
);

  localparam int NDIR = 2;

  logic [NDIR-1:0]            dma_en_v;
  logic [NDIR-1:0]            stb_v;
  logic [NDIR-1:0]            req_v;
  logic [NDIR-1:0][LVL_W-1:0] lvl_v;

  // index 1 = receive, index 0 = transmit
  assign dma_en_v = {rx_dma_en, tx_dma_en};
  assign stb_v    = {rx_rd_stb, tx_wr_stb};
  assign lvl_v    = {rx_full_lvl, tx_empty_lvl};

  for (genvar d = 0; d < NDIR; d++) begin : g_lane
    dma_wm_lane #(
      .LVL_W (LVL_W),
      .DIR   ((d == 1) ? DIR_RX : DIR_TX)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chan_en),
      .dma_en (dma_en_v[d]),
      .lvl    (lvl_v[d]),
      .fill   (fifo_bytes),
      .stb    (stb_v[d]),
      .req    (req_v[d])
    );
  end

  assign rx_req = req_v[1];
  assign tx_req = req_v[0];

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> (!rx_req && !tx_req));

endmodule

// File: tb/test_dma_wm_req.sv
module test_dma_wm_req;

  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mrx = 1'b0, mtx = 1'b0, srx = 1'b0, stx = 1'b0;
  logic [LVL_W-1:0] lrx = '0, ltx = '0, fill = '0;
  logic rx_req, tx_req;

  int rx_owed = 0, tx_owed = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_wm_req #(.LVL_W(LVL_W)) i_dma_wm_req (
    .clk(clk), .rst_n(rst_n), .chan_en(en),
    .rx_dma_en(mrx), .tx_dma_en(mtx),
    .rx_full_lvl(lrx), .tx_empty_lvl(ltx), .fifo_bytes(fill),
    .rx_rd_stb(srx), .tx_wr_stb(stx),
    .rx_req(rx_req), .tx_req(tx_req)
  );

  function automatic int rest_of(input int lvl);
    if (lvl < 1) return 0;
    return lvl - 1;
  endfunction

  function automatic bit exp_rx();
    return en && mrx && rx_owed == 0 && (int'(fill) >= int'(lrx));
  endfunction

  function automatic bit exp_tx();
    return en && mtx && tx_owed == 0 && (int'(fill) < int'(ltx));
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, check combinational outputs, advance model at rising edge.
  task automatic apply(input bit e, input bit mr, input bit mt,
                       input int lr, input int lt, input int f,
                       input bit sr, input bit st,
                       input string trx, input string ttx);
    bit er, et;
    en = e; mrx = mr; mtx = mt;
    lrx = LVL_W'(lr); ltx = LVL_W'(lt); fill = LVL_W'(f);
    srx = sr; stx = st;
    #1;
    er = exp_rx(); et = exp_tx();
    check(trx, "rx_req", rx_req, er);
    check(ttx, "tx_req", tx_req, et);
    @(posedge clk);
    if (!en) rx_owed = 0;
    else if (rx_owed != 0) begin if (srx) rx_owed--; end
    else if (er && srx) rx_owed = rest_of(int'(lrx));
    if (!en) tx_owed = 0;
    else if (tx_owed != 0) begin if (stx) tx_owed--; end
    else if (et && stx) tx_owed = rest_of(int'(ltx));
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    // reset state: channel off, both low (R7)
    check("R7", "rx_req in reset", rx_req, 1'b0);
    check("R7", "tx_req in reset", tx_req, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // right after reset, lines follow the level (R1, R2)
    apply(1, 1, 1, 8, 20, 10, 0, 0, "R1", "R2");

    // R4 / R5: receive burst of 4, transmit burst of 3
    apply(1, 1, 1, 4, 3, 10, 1, 0, "R4", "R2");
    apply(1, 1, 1, 4, 3, 10, 0, 0, "R4", "R2");
    apply(1, 1, 1, 4, 3, 2, 1, 1, "R5", "R4");
    apply(1, 1, 1, 4, 3, 2, 0, 0, "R5", "R4");
    apply(1, 1, 1, 4, 3, 10, 1, 1, "R5", "R5");
    apply(1, 1, 1, 4, 3, 10, 1, 1, "R5", "R5");
    apply(1, 1, 1, 4, 3, 2, 0, 0, "R5", "R5");
    apply(1, 1, 1, 4, 3, 10, 0, 0, "R5", "R9");

    // R6: level changed during a burst
    apply(1, 1, 0, 3, 0, 10, 1, 0, "R6", "R8");
    apply(1, 1, 0, 1, 0, 10, 1, 0, "R6", "R8");
    apply(1, 1, 0, 1, 0, 10, 0, 0, "R6", "R8");
    apply(1, 1, 0, 1, 0, 10, 1, 0, "R6", "R8");
    apply(1, 1, 0, 1, 0, 10, 0, 0, "R6", "R8");

    // R7: disable in the middle of a burst, then enable again
    apply(1, 1, 1, 6, 6, 5, 1, 1, "R7", "R7");
    apply(1, 1, 1, 6, 6, 5, 1, 0, "R7", "R7");
    apply(0, 1, 1, 6, 6, 5, 1, 1, "R7", "R7");
    apply(1, 1, 1, 6, 6, 5, 0, 0, "R7", "R7");

    // R8: level value 0
    apply(1, 1, 1, 0, 0, 0, 1, 1, "R8", "R8");
    apply(1, 1, 1, 0, 0, 0, 1, 1, "R8", "R8");
    apply(1, 1, 1, 0, 0, 63, 0, 1, "R8", "R8");

    // R3: masked line, strobes start no burst
    apply(1, 0, 0, 4, 10, 5, 1, 1, "R3", "R3");
    apply(1, 0, 0, 4, 10, 5, 1, 1, "R3", "R3");
    apply(1, 1, 1, 4, 10, 5, 0, 0, "R3", "R3");

    // R9: only transmit accesses while receive is busy
    apply(1, 1, 1, 5, 10, 5, 1, 0, "R9", "R9");
    apply(1, 1, 1, 5, 10, 5, 0, 1, "R9", "R9");
    apply(1, 1, 1, 5, 10, 5, 0, 1, "R9", "R9");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      apply(($urandom % 16) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
            $urandom % 12, $urandom % 40, $urandom % 48,
            $urandom % 2, $urandom % 2, "R1", "R2");
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule